// File: doc/BRIEF.md
# SPI Status Byte Responder

This block is the serial output path of an SPI slave that answers one command: a status read. While chip select is low it shifts an 8-bit command in on rising SCK. When that command is the status-read code, it then drives the status byte out on SO, one bit per falling SCK, most significant bit first. It keeps repeating the byte for as long as the host keeps clocking. SO is high-impedance at all other times, and `so_oe` reports when the pin is being driven.

The byte is built live from three sources: a ready flag (the inverse of the `busy` input), the result of the last compare (the `cmp_mismatch` input), and a fixed family code. Because the selected bit goes straight to the pin, a host can stop SCK while the ready bit is on SO. It then watches the pin rise from 0 to 1 at the moment `busy` clears. The same logic works whether SCK idles low (mode 0) or high (mode 3) when chip select falls. Every piece of state is cleared asynchronously by chip select going high.

Top module: `spi_status_responder`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0 and `so` is high-impedance.
- R2: The command is captured from `si` on rising SCK, MSB first. Only the value 0x57 starts a status read. Any other value leaves `so_oe` at 0 and `so` undriven for the rest of that selection.
- R3: The status MSB (bit 7) appears on the first falling SCK after the eighth rising SCK. Each later falling SCK moves to the next lower bit.
- R4: Status bit 7 is 1 when `busy` is 0 (ready), and 0 when `busy` is 1.
- R5: Status bit 6 equals `cmp_mismatch`: 0 means the compare matched, 1 means it did not.
- R6: Status bits 5, 4, 3 are 0, 1, 0. Bits 2, 1, 0 are driven as 0.
- R7: After bit 0, the next falling SCK returns to bit 7. Every repetition reflects the values of `busy` and `cmp_mismatch` at the time each bit is on the pin.
- R8: If SCK stops while bit 7 is on `so`, `so` follows `busy` without further clocks.
- R9: Both SCK idle-low (mode 0) and SCK idle-high (mode 3) at the falling edge of `cs_n` give the same bit sequence.
- R10: Raising `cs_n` at any point, including in the middle of a bit, clears the command and bit state at once. The next selection must resend the command before any status bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Chip select, active low; high clears all state |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, sampled on rising SCK |
| busy | input | 1 | Device busy flag (status bit 7 is its inverse) |
| cmp_mismatch | input | 1 | Last compare result, 1 = mismatch |
| so | output | 1 | Serial data out, high-impedance when not driving |
| so_oe | output | 1 | High while `so` is driven |

## Verification
The hardest case to reach is the stalled poll. Chip select must be low, the command must have been accepted, and SCK must be frozen low just after the falling edge that put bit 7 on the pin. Only then is `busy` toggled, with no clock activity at all. The bench builds this state from a directed sequence in both SCK idle polarities. It then flips `busy` several times while SCK stays still, and checks `so` after each flip. Stimulus is otherwise random: commands, repeat lengths, and changes to `busy` and `cmp_mismatch` between bits. It also includes chip-select aborts partway through a bit.

// File: rtl/statrsp_pkg.sv
package statrsp_pkg;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned STAT_W    = 8;
  localparam logic [CMD_W-1:0] CMD_STATUS = 8'h57;
  localparam logic [2:0] FAMILY_CODE = 3'b010;
  localparam int unsigned RDY_POS   = STAT_W - 1;
  localparam int unsigned CMP_POS   = STAT_W - 2;
  localparam int unsigned FAM_LSB   = STAT_W - 5;
  localparam int unsigned CNT_W     = $clog2(CMD_W + 1);
  localparam int unsigned IDX_W     = $clog2(STAT_W);
  typedef logic [STAT_W-1:0] stat_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/ssr_cmd_capture.sv
module ssr_cmd_capture
  import statrsp_pkg::*;
(
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic armed
);
  logic [CMD_W-1:0] shreg;
  logic [CNT_W-1:0] nrise;
  logic             full;

  assign full = (nrise == CNT_W'(CMD_W));

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      shreg <= '0;
      nrise <= '0;
    end else if (!full) begin
      shreg <= {shreg[CMD_W-2:0], si};
      nrise <= nrise + 1'b1;
    end
  end

  assign armed = full && (shreg == CMD_STATUS);
endmodule

// File: rtl/ssr_status_build.sv
module ssr_status_build
  import statrsp_pkg::*;
(
  input  logic  busy,
  input  logic  cmp_mismatch,
  output stat_t status
);
  genvar g;
  generate
    for (g = 0; g < STAT_W; g++) begin : g_bit
      if (g == RDY_POS) begin : g_rdy
        assign status[g] = ~busy;
      end else if (g == CMP_POS) begin : g_cmp
        assign status[g] = cmp_mismatch;
      end else if (g >= FAM_LSB && g < CMP_POS) begin : g_fam
        assign status[g] = FAMILY_CODE[g - FAM_LSB];
      end else begin : g_zero
        assign status[g] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/ssr_bit_sequencer.sv
module ssr_bit_sequencer
  import statrsp_pkg::*;
(
  input  logic cs_n,
  input  logic sck,
  input  logic armed,
  output logic active,
  output idx_t idx
);
  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      active <= 1'b0;
      idx    <= idx_t'(STAT_W - 1);
    end else if (armed) begin
      if (!active) begin
        active <= 1'b1;
        idx    <= idx_t'(STAT_W - 1);
      end else if (idx == '0) begin
        idx    <= idx_t'(STAT_W - 1);
      end else begin
        idx    <= idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_status_responder.sv
module spi_status_responder
  import statrsp_pkg::*;
(
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic busy,
  input  logic cmp_mismatch,
  output logic so,
  output logic so_oe
);
  logic  armed;
  logic  active;
  idx_t  idx;
  stat_t status;

  ssr_cmd_capture u_cap (
    .cs_n  (cs_n),
    .sck   (sck),
    .si    (si),
    .armed (armed)
  );

  ssr_status_build u_build (
    .busy         (busy),
    .cmp_mismatch (cmp_mismatch),
    .status       (status)
  );

  ssr_bit_sequencer u_seq (
    .cs_n   (cs_n),
    .sck    (sck),
    .armed  (armed),
    .active (active),
    .idx    (idx)
  );

  assign so_oe = active;
  assign so    = active ? status[idx] : 1'bz;
endmodule

module ssr_checker
  import statrsp_pkg::*;
(
  input logic cs_n,
  input logic sck,
  input logic si,
  input logic busy,
  input logic cmp_mismatch,
  input logic so,
  input logic so_oe
);
  logic [CMD_W-1:0] c_cmd;
  logic [CNT_W-1:0] c_rise;
  logic             c_seen;
  logic [IDX_W-1:0] c_pos;
  logic             c_go;

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      c_cmd  <= '0;
      c_rise <= '0;
    end else if (c_rise < CNT_W'(CMD_W)) begin
      c_cmd  <= {c_cmd[CMD_W-2:0], si};
      c_rise <= c_rise + 1'b1;
    end
  end

  assign c_go = (c_rise == CNT_W'(CMD_W)) && (c_cmd == CMD_STATUS);

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      c_seen <= 1'b0;
      c_pos  <= '1;
    end else if (c_go) begin
      c_seen <= 1'b1;
      c_pos  <= c_seen ? c_pos - 1'b1 : '1;
    end
  end

  // R1
  oe_idle_chk: assert property (@(posedge sck) cs_n |-> !so_oe);

  // R2
  no_early_drive_chk: assert property (@(posedge sck) disable iff (cs_n)
    !c_seen |-> !so_oe);

  // R4
  ready_bit_chk: assert property (@(posedge sck) disable iff (cs_n)
    (so_oe && c_pos == 3'd7) |-> (so == !busy));

  // R5
  cmp_bit_chk: assert property (@(posedge sck) disable iff (cs_n)
    (so_oe && c_pos == 3'd6) |-> (so == cmp_mismatch));

  // R6
  family_one_chk: assert property (@(posedge sck) disable iff (cs_n)
    (so_oe && c_pos == 3'd4) |-> so);

  // R6
  zero_bits_chk: assert property (@(posedge sck) disable iff (cs_n)
    (so_oe && (c_pos == 3'd5 || c_pos <= 3'd3)) |-> !so);
endmodule

bind spi_status_responder ssr_checker u_ssr_chk (
  .cs_n         (cs_n),
  .sck          (sck),
  .si           (si),
  .busy         (busy),
  .cmp_mismatch (cmp_mismatch),
  .so           (so),
  .so_oe        (so_oe)
);

// File: tb/spi_status_responder_bench.sv
module spi_status_responder_bench;
  logic clk = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0, cmp_mismatch = 1'b0;
  wire  so;
  wire  so_oe;
  int   n_chk = 0, n_bad = 0, n_clk = 0;

  always #2.5 clk = ~clk;

  spi_status_responder u_spi_status_responder (
    .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .cmp_mismatch(cmp_mismatch), .so(so), .so_oe(so_oe)
  );

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 190000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d exp<190000", n_clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic exp_bit(int pos, logic b, logic c);
    case (pos)
      7: return ~b;
      6: return c;
      4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic begin_sel(bit mode3);
    sck = mode3; hclk(2);
    chk(so_oe == 1'b0, "R1 idle", {7'd0, so_oe}, 8'd0);
    cs_n = 1'b0; hclk(2);
  endtask

  task automatic send_bit(logic b);
    if (sck) begin sck = 1'b0; hclk(2); end
    si = b; hclk(2);
    sck = 1'b1; hclk(2);
  endtask

  task automatic send_cmd(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // one falling edge, then check the bit at the given position
  task automatic read_bit(int pos, string req);
    logic e;
    sck = 1'b0; hclk(1);
    e = exp_bit(pos, busy, cmp_mismatch);
    chk(so_oe === 1'b1 && so === e, req, {6'd0, so_oe, so}, {7'd1, e});
    si = 1'($urandom_range(0, 1)); hclk(1);
    sck = 1'b1; hclk(2);
  endtask

  task automatic end_sel(bit mode3);
    if (!mode3) begin sck = 1'b0; hclk(2); end
    cs_n = 1'b1; hclk(1);
    chk(so_oe == 1'b0, "R10 release", {7'd0, so_oe}, 8'd0);
    hclk(1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0057));
    hclk(4);
    // R1 reset state
    chk(so_oe == 1'b0, "R1 reset", {7'd0, so_oe}, 8'd0);

    // directed: one byte in each mode, fixed inputs (R3 R4 R5 R6 R9)
    for (int m = 0; m < 2; m++) begin
      busy = 1'b1; cmp_mismatch = 1'b1;
      begin_sel(m[0]);
      send_cmd(8'h57);
      chk(so_oe == 1'b0, "R3 not before fall", {7'd0, so_oe}, 8'd0);
      for (int p = 7; p >= 0; p--) read_bit(p, m ? "R9 mode3 byte" : "R3 R6 mode0 byte");
      end_sel(m[0]);
    end

    // R8 stall polling, both modes
    for (int m = 0; m < 2; m++) begin
      busy = 1'b1;
      begin_sel(m[0]);
      send_cmd(8'h57);
      sck = 1'b0; hclk(2);
      for (int k = 0; k < 6; k++) begin
        busy = k[0] ? 1'b1 : 1'b0; hclk(1);
        chk(so_oe === 1'b1 && so === ~busy, "R8 stall poll", {7'd0, so}, {7'd0, ~busy});
      end
      cs_n = 1'b1; hclk(1);
      chk(so_oe == 1'b0, "R10 stall release", {7'd0, so_oe}, 8'd0);
      hclk(1);
    end

    // R2 wrong commands, including near misses
    for (int t = 0; t < 12; t++) begin
      logic [7:0] c;
      c = (t < 4) ? (8'h57 ^ (8'h01 << (t * 2))) : 8'($urandom_range(0, 255));
      if (c == 8'h57) c = 8'hD7;
      begin_sel(t[0]);
      send_cmd(c);
      for (int k = 0; k < 10; k++) begin
        sck = 1'b0; hclk(1);
        chk(so_oe == 1'b0, "R2 wrong cmd", c, 8'h57);
        hclk(1); sck = 1'b1; hclk(2);
      end
      end_sel(t[0]);
    end

    // R10 abort mid-command and mid-bit, then a fresh selection must resend
    begin_sel(1'b0);
    send_cmd(8'h57);
    read_bit(7, "R4 pre-abort");
    sck = 1'b0; hclk(1);
    cs_n = 1'b1; hclk(1);
    chk(so_oe == 1'b0, "R10 mid-bit abort", {7'd0, so_oe}, 8'd0);
    begin_sel(1'b0);
    for (int i = 7; i >= 4; i--) send_bit(8'h57 >> i);
    cs_n = 1'b1; hclk(2);
    begin_sel(1'b0);
    for (int i = 3; i >= 0; i--) send_bit(8'h57 >> i);
    for (int k = 0; k < 6; k++) begin
      sck = 1'b0; hclk(1);
      chk(so_oe == 1'b0, "R10 partial cmd not kept", {7'd0, so_oe}, 8'd0);
      hclk(1); sck = 1'b1; hclk(2);
    end
    end_sel(1'b0);

    // random: repeated bytes with live inputs changing between bits (R7 R4 R5)
    for (int t = 0; t < 24; t++) begin
      int nb;
      nb = $urandom_range(9, 30);
      begin_sel(1'($urandom_range(0, 1)));
      send_cmd(8'h57);
      for (int k = 0; k < nb; k++) begin
        busy = 1'($urandom_range(0, 1));
        cmp_mismatch = 1'($urandom_range(0, 1));
        read_bit(7 - (k % 8), k >= 8 ? "R7 repeat" : "R4 R5 live");
      end
      end_sel(sck);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule